// File: doc/BRIEF.md
# Interrupt Coalescing Counter and Idle Timer

This block cuts the interrupt rate of one DMA channel. It combines two mechanisms. A completion counter asks for a completion interrupt only once a programmed number of completion events has been seen. A delay timer asks for a separate interrupt when no new packet follows within a programmed timeout after the last packet ended.

The block takes single-cycle pulses for completion events, packet start and packet end. It also takes a threshold write strobe with its 8-bit data and an 8-bit delay setting that is held as a level. It drives two single-cycle event outputs, which feed the channel status logic. Register decoding and interrupt masking belong to the surrounding logic.

The threshold counter counts down from the stored threshold. The timer counts in steps of 125 clocks and starts when a packet ends. A new packet or a timeout stops the timer, and a delay of 0 turns the timer off.

Top module: `irq_coalesce`

## Requirements
- R1: During and right after reset, `cmplIrq` and `dlyIrq` are low, the stored threshold is 1 and the timer is idle.
- R2: A `thrWrite` pulse with nonzero `threshIn` stores that value and reloads the countdown to it. A completion event in the same cycle is not counted.
- R3: A `thrWrite` pulse with `threshIn` equal to 0 is ignored. The stored threshold and the countdown keep their values, and a completion event in that cycle counts normally.
- R4: With stored threshold T, `cmplIrq` is high for one cycle, in the cycle after the edge that samples the T-th completion event since the last reload. The countdown then reloads to T.
- R5: With threshold 1, every completion event produces a `cmplIrq` pulse in the following cycle.
- R6: With delay D nonzero, `dlyIrq` is high for one cycle, starting 125*D clock edges after the edge that sampled `pktEnd`, provided no `pktStart` or `pktEnd` is sampled in between.
- R7: A sampled `pktStart` stops the timer. No `dlyIrq` follows until a later `pktEnd`.
- R8: A new `pktEnd` restarts the full 125*D window. If both packet pulses come in the same cycle, the end wins and the timer starts.
- R9: With `delayIn` equal to 0, the timer is cleared and stopped and `dlyIrq` never rises.
- R10: After a timeout the timer stays idle. No second `dlyIrq` follows without a new `pktEnd`.
- R11: A `pktStart` or `pktEnd` sampled on the edge that would complete the timeout cancels that timeout, and the packet rule applies.
- R12: When a threshold hit and a timeout fall on the same edge, both outputs pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmplEvt | input | 1 | Completion event pulse |
| pktStart | input | 1 | New packet received pulse |
| pktEnd | input | 1 | Packet finished pulse |
| thrWrite | input | 1 | Threshold write strobe |
| threshIn | input | 8 | Threshold write data |
| delayIn | input | 8 | Delay setting in units of 125 clocks, 0 = off |
| cmplIrq | output | 1 | Completion interrupt event |
| dlyIrq | output | 1 | Delay timeout interrupt event |

## Verification
The assertions assume that `delayIn` does not change to a different nonzero value while the timer is running. They also assume that each strobe is a single-cycle pulse, sampled on the clock edge. The bench keeps to this in two ways. It changes the delay only while the timer is idle, or it passes through a cycle of delay 0, which disarms the timer. Random phases mix sparse completion, start, end and threshold-write pulses, including writes of 0, at a fixed delay. Directed cases aim at the exact timeout edge and at the collisions there.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  typedef struct packed {
    logic thrWr;      // store new threshold and reload countdown
    logic cntReload;  // reload countdown from stored threshold
    logic cntDec;     // decrement countdown
    logic tmrClr;     // clear prescaler and unit counter
    logic tmrRun;     // advance prescaler (and units on wrap)
  } coalStrobe_t;
endpackage

// File: rtl/irq_coal_dp.sv
module irq_coal_dp
  import irq_coal_pkg::*;
#(
  parameter int THR_W    = 8,
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 125
) (
  input  logic             clk,
  input  logic             rstN,
  input  coalStrobe_t      strb,
  input  logic [THR_W-1:0] threshIn,
  input  logic [DLY_W-1:0] delayIn,
  output logic             cntAtOne,
  output logic             preAtTop,
  output logic             unitHit
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

  logic [THR_W-1:0] thrReg;
  logic [THR_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [DLY_W-1:0] units;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg <= THR_W'(1);
      cnt    <= THR_W'(1);
    end else if (strb.thrWr) begin
      thrReg <= threshIn;
      cnt    <= threshIn;
    end else if (strb.cntReload) begin
      cnt <= thrReg;
    end else if (strb.cntDec) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre   <= '0;
      units <= '0;
    end else if (strb.tmrClr) begin
      pre   <= '0;
      units <= '0;
    end else if (strb.tmrRun) begin
      if (preAtTop) begin
        pre   <= '0;
        units <= units + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign cntAtOne = (cnt == THR_W'(1));
  assign preAtTop = (pre == PRE_TOP);
  assign unitHit  = (({1'b0, units} + 1'b1) == {1'b0, delayIn});

  AST_THR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    thrReg != '0); // R3
  AST_CNT_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) && (cnt <= thrReg)); // R4
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pre <= PRE_TOP); // R6
endmodule

// File: rtl/irq_coal_ctrl.sv
module irq_coal_ctrl
  import irq_coal_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmplEvt,
  input  logic             pktStart,
  input  logic             pktEnd,
  input  logic             thrWrite,
  input  logic [THR_W-1:0] threshIn,
  input  logic [DLY_W-1:0] delayIn,
  input  logic             cntAtOne,
  input  logic             preAtTop,
  input  logic             unitHit,
  output coalStrobe_t      strb,
  output logic             cmplIrq,
  output logic             dlyIrq
);
  logic thrOk;
  logic delayOn;
  logic pktAny;
  logic armed;
  logic timeout;

  assign thrOk   = thrWrite && (threshIn != '0);
  assign delayOn = (delayIn != '0);
  assign pktAny  = pktStart || pktEnd;
  assign timeout = armed && delayOn && !pktAny && preAtTop && unitHit;

  always_comb begin
    strb           = '0;
    strb.thrWr     = thrOk;
    strb.cntReload = !thrOk && cmplEvt && cntAtOne;
    strb.cntDec    = !thrOk && cmplEvt && !cntAtOne;
    strb.tmrClr    = pktAny || timeout || !armed || !delayOn;
    strb.tmrRun    = armed && delayOn && !pktAny && !timeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      cmplIrq <= 1'b0;
      dlyIrq  <= 1'b0;
    end else begin
      cmplIrq <= strb.cntReload;
      dlyIrq  <= timeout;
      if (!delayOn)      armed <= 1'b0;
      else if (pktEnd)   armed <= 1'b1;
      else if (pktStart) armed <= 1'b0;
      else if (timeout)  armed <= 1'b0;
    end
  end

  AST_CMPL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cmplIrq |-> $past(cmplEvt)); // R4
  AST_WRITE_SWALLOWS: assert property (@(posedge clk) disable iff (!rstN)
    cmplIrq |-> !$past(thrWrite && (threshIn != '0))); // R2
  AST_DLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    dlyIrq |-> ($past(delayIn) != '0)); // R9
  AST_DLY_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    dlyIrq |-> !armed); // R10
  AST_DLY_NO_PKT: assert property (@(posedge clk) disable iff (!rstN)
    dlyIrq |-> !$past(pktStart || pktEnd)); // R11
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coal_pkg::*;
#(
  parameter int THR_W    = 8,
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 125
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmplEvt,
  input  logic             pktStart,
  input  logic             pktEnd,
  input  logic             thrWrite,
  input  logic [THR_W-1:0] threshIn,
  input  logic [DLY_W-1:0] delayIn,
  output logic             cmplIrq,
  output logic             dlyIrq
);
  coalStrobe_t strb;
  logic cntAtOne;
  logic preAtTop;
  logic unitHit;

  irq_coal_ctrl #(.THR_W(THR_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmplEvt(cmplEvt), .pktStart(pktStart),
    .pktEnd(pktEnd), .thrWrite(thrWrite), .threshIn(threshIn),
    .delayIn(delayIn), .cntAtOne(cntAtOne), .preAtTop(preAtTop),
    .unitHit(unitHit), .strb(strb), .cmplIrq(cmplIrq), .dlyIrq(dlyIrq)
  );

  irq_coal_dp #(.THR_W(THR_W), .DLY_W(DLY_W), .PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .threshIn(threshIn),
    .delayIn(delayIn), .cntAtOne(cntAtOne), .preAtTop(preAtTop),
    .unitHit(unitHit)
  );
endmodule

// File: tb/irq_coalesce_test.sv
`timescale 1ns/1ps
module irq_coalesce_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmplEvt = 1'b0, pktStart = 1'b0, pktEnd = 1'b0, thrWrite = 1'b0;
  logic [7:0] threshIn = '0, delayIn = '0;
  logic cmplIrq, dlyIrq;

  irq_coalesce uut (
    .clk(clk), .rstN(rstN), .cmplEvt(cmplEvt), .pktStart(pktStart),
    .pktEnd(pktEnd), .thrWrite(thrWrite), .threshIn(threshIn),
    .delayIn(delayIn), .cmplIrq(cmplIrq), .dlyIrq(dlyIrq)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  string curTag = "R1";
  int dlyCnt = 0, cmplCnt = 0;
  logic obsC = 0, obsD = 0;
  bit done = 0;

  // behavioural reference: elapsed-cycle formulation of the timer
  int mThr, mLeft, mEl;
  bit mArmed;
  logic expC = 0, expD = 0;

  function automatic int timeoutCycles(input int d);
    return 125 * d;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mThr = 1; mLeft = 1; mArmed = 0; mEl = 0; expC = 0; expD = 0;
    end else begin
      expC = 0;
      expD = 0;
      if (thrWrite && threshIn != 0) begin
        mThr = threshIn; mLeft = threshIn;
      end else if (cmplEvt) begin
        if (mLeft == 1) begin expC = 1; mLeft = mThr; end
        else mLeft = mLeft - 1;
      end
      if (delayIn == 0) mArmed = 0;
      else if (pktEnd) begin mArmed = 1; mEl = 0; end
      else if (pktStart) mArmed = 0;
      else if (mArmed) begin
        mEl = mEl + 1;
        if (mEl == timeoutCycles(delayIn)) begin expD = 1; mArmed = 0; end
      end
    end
  end

  task automatic expectEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic e,
                      input logic w, input logic [7:0] t, input logic [7:0] d);
    @(negedge clk);
    obsC = cmplIrq; obsD = dlyIrq;
    expectEq({curTag, " cmplIrq"}, int'(cmplIrq), int'(expC));
    expectEq({curTag, " dlyIrq"}, int'(dlyIrq), int'(expD));
    if (cmplIrq) cmplCnt++;
    if (dlyIrq) dlyCnt++;
    cmplEvt = c; pktStart = s; pktEnd = e; thrWrite = w; threshIn = t; delayIn = d;
  endtask

  task automatic idle(input int n, input logic [7:0] d);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'd0, d);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    curTag = "R1";
    idle(4, 8'd0);
    @(negedge clk); rstN = 1'b1;
    idle(3, 8'd0);

    curTag = "R5";
    base = cmplCnt;
    for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0, 8'd0, 8'd0); idle(2, 8'd0); end
    expectEq("R5 pulses", cmplCnt - base, 3);

    curTag = "R2";
    step(1, 0, 0, 1, 8'd3, 8'd0);
    idle(1, 8'd0);
    base = cmplCnt;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'd0, 8'd0);
    idle(2, 8'd0);
    expectEq("R2 pulses", cmplCnt - base, 1);

    curTag = "R3";
    base = cmplCnt;
    step(1, 0, 0, 1, 8'd0, 8'd0);
    step(1, 0, 0, 0, 8'd0, 8'd0);
    step(1, 0, 0, 0, 8'd0, 8'd0);
    idle(2, 8'd0);
    expectEq("R3 pulses", cmplCnt - base, 1);

    curTag = "R4";
    step(0, 0, 0, 1, 8'd4, 8'd0);
    base = cmplCnt;
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 8'd0, 8'd0);
    idle(2, 8'd0);
    expectEq("R4 pulses", cmplCnt - base, 2);

    curTag = "R9";
    base = dlyCnt;
    step(0, 0, 1, 0, 8'd0, 8'd0);
    idle(300, 8'd0);
    expectEq("R9 pulses", dlyCnt - base, 0);

    curTag = "R6";
    base = dlyCnt;
    step(0, 0, 1, 0, 8'd0, 8'd2);
    idle(300, 8'd2);
    expectEq("R6 pulses", dlyCnt - base, 1);
    curTag = "R10";
    base = dlyCnt;
    idle(300, 8'd2);
    expectEq("R10 pulses", dlyCnt - base, 0);

    curTag = "R7";
    base = dlyCnt;
    step(0, 0, 1, 0, 8'd0, 8'd1);
    idle(60, 8'd1);
    step(0, 1, 0, 0, 8'd0, 8'd1);
    idle(300, 8'd1);
    expectEq("R7 pulses", dlyCnt - base, 0);

    curTag = "R8";
    base = dlyCnt;
    step(0, 0, 1, 0, 8'd0, 8'd1);
    idle(100, 8'd1);
    step(0, 1, 1, 0, 8'd0, 8'd1);
    idle(110, 8'd1);
    expectEq("R8 early", dlyCnt - base, 0);
    idle(40, 8'd1);
    expectEq("R8 pulses", dlyCnt - base, 1);

    curTag = "R11";
    base = dlyCnt;
    step(0, 0, 1, 0, 8'd0, 8'd1);
    idle(124, 8'd1);
    step(0, 0, 1, 0, 8'd0, 8'd1);
    idle(2, 8'd1);
    expectEq("R11 cancel", dlyCnt - base, 0);
    idle(200, 8'd1);
    expectEq("R11 restart", dlyCnt - base, 1);

    curTag = "R12";
    step(0, 0, 0, 1, 8'd1, 8'd1);
    step(0, 0, 1, 0, 8'd0, 8'd1);
    idle(124, 8'd1);
    step(1, 0, 0, 0, 8'd0, 8'd1);
    idle(1, 8'd1);
    expectEq("R12 cmpl", int'(obsC), 1);
    expectEq("R12 dly", int'(obsD), 1);
    idle(2, 8'd1);

    curTag = "R4 R6 random";
    for (int ph = 0; ph < 2; ph++) begin
      logic [7:0] d;
      d = (ph == 0) ? 8'd1 : 8'd2;
      step(0, 0, 0, 0, 8'd0, 8'd0);
      for (int i = 0; i < 3000; i++)
        step(($urandom % 8) == 0, ($urandom % 300) == 0, ($urandom % 200) == 0,
             ($urandom % 150) == 0, 8'($urandom % 6), d);
    end
    idle(2, 8'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule